// File: doc/BRIEF.md
# Background Flash Word Streamer

This block moves a linear run of 32-bit words from flash into a two-word FIFO without any help from a processor. A DMA engine then empties the FIFO. Software writes a word-aligned start address and a word count through a small register bus. From then on the engine makes one flash read per word. It uses the shared flash port only in cycles when normal execute-in-place traffic is not asking for it. The address and count registers change as the stream runs, so software can read them to follow progress. Writing a count of zero aborts the stream. Any read already accepted by the flash is then dropped when its data returns, so a new stream can start in the next cycle.

The register bus has a 2-bit select. Select 0 is the stream address, select 1 is the word count, select 2 is FIFO data (a read pops one word), and select 3 is status. Read data is combinational and is valid in the same cycle as `reg_rd`. Writes take effect at the clock edge that samples `reg_wr`.

A three-state machine controls when reads are made:
- ST_IDLE: the count is zero and no requests are made.
- ST_STREAM: the count is nonzero and there is room, so a request goes out in every cycle in which `xip_busy` is low.
- ST_HOLD: the count is nonzero but the engine must wait. Either the FIFO words plus the live reads would reach two, or the total number of outstanding reads (live and dropped) would reach the outstanding limit.

The next state is worked out at every edge from the values the count and occupancy will take at that edge:
- Any state goes to ST_IDLE when the count becomes zero (by a write or by the last accepted read).
- ST_IDLE goes to ST_STREAM or ST_HOLD on a nonzero count write.
- ST_STREAM goes to ST_HOLD when the room runs out.
- ST_HOLD goes back to ST_STREAM when a pop or a returning response frees a place.

Top module: `flash_stream_engine`

## Requirements
- R1: After reset the address reads 0, the count reads 0, status reads 1 (bit 0 empty = 1, bit 1 full = 0) and `fl_req` is low.
- R2: A write to select 0 stores bits 31:2 of the data. Reading select 0 returns those bits with bits 1:0 as zero.
- R3: The count is CNT_W (22) bits wide, and a read of select 1 returns the written value truncated to 22 bits. After a nonzero count write, `fl_req` is high in the next cycle (when `xip_busy` is low), with `fl_addr` equal to the stream address.
- R4: Each accepted read (`fl_req` and `fl_gnt` both high) adds 4 to the byte address and subtracts 1 from the count at that edge. No request is made while the count is zero.
- R5: `fl_req` is low in every cycle in which `xip_busy` is high, and the count does not change during such cycles.
- R6: Read responses (`fl_rvalid`) go into the FIFO in the order they arrive. Status bit 0 is empty and status bit 1 is full.
- R7: No request is made while the FIFO words plus the reads in flight reach two, so the FIFO never overflows.
- R8: A read of select 2 returns the oldest FIFO word and pops it at that edge.
- R9: A read of select 2 while the FIFO is empty returns 0 and leaves the status unchanged.
- R10: A count write of zero drops `fl_req` from the next cycle on. Responses to reads that were accepted before the abort never reach the FIFO. A new stream started right afterwards delivers its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at select 2) |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 FIFO data, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| xip_busy | input | 1 | Execute-in-place traffic wants the flash port this cycle |
| fl_req | output | 1 | Stream read request |
| fl_addr | output | 32 | Byte address of the requested word |
| fl_gnt | input | 1 | Flash accepts the request this cycle |
| fl_rvalid | input | 1 | Read data returning, in request order |
| fl_rdata | input | 32 | Returned read data |

## Verification
Register writes and FIFO pops take effect at the edge that samples the strobe. The bench therefore drives strobes on the falling edge and reads registers back one cycle later, just after the next falling edge. Because the state is registered, `fl_req` rises one cycle after a nonzero count write, and the bench samples it 1 ns after the falling edge that follows the write. Flash data returns two edges after acceptance in normal tests and six edges in the abort test. Multi-word transfers are checked only after a settling wait much longer than that latency, so the expected count, address, status and FIFO contents are fixed values and do not depend on the exact cycle at which each event happens.

// File: rtl/fse_pkg.sv
package fse_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_HOLD   = 2'd2
    } fse_state_t;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;
endpackage

// File: rtl/fse_fifo.sv
module fse_fifo #(
    parameter int DEPTH = 2,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [31:0]      push_data,
    input  logic             pop,
    output logic [31:0]      head,
    output logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [31:0]      mem [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [LVL_W-1:0] lvl_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (push) wp_q <= bump(wp_q);
            if (pop)  rp_q <= bump(rp_q);
            lvl_q <= lvl_q + LVL_W'(push) - LVL_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= push_data;
    end

    assign level = lvl_q;
    assign empty = (lvl_q == '0);
    assign full  = (lvl_q == LVL_W'(DEPTH));
    assign head  = empty ? 32'd0 : mem[rp_q];

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));

    p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty);
endmodule

// File: rtl/fse_ctrl.sv
module fse_ctrl
    import fse_pkg::*;
#(
    parameter int CNT_W   = 22,
    parameter int DEPTH   = 2,
    parameter int OUT_MAX = 4,
    parameter int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_addr,
    input  logic             wr_cnt,
    input  logic [31:0]      wdata,
    input  logic             xip_busy,
    input  logic             fl_gnt,
    input  logic             fl_rvalid,
    input  logic [LVL_W-1:0] fifo_lvl,
    input  logic             pop,
    output logic             fl_req,
    output logic [31:0]      fl_addr,
    output logic [29:0]      addr_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             push
);
    localparam int OUT_W = $clog2(OUT_MAX + 1);
    localparam int SUM_W = ((OUT_W > LVL_W) ? OUT_W : LVL_W) + 2;

    fse_state_t       state_q, state_nxt;
    logic [OUT_W-1:0] live_q, drop_q;
    logic [SUM_W-1:0] live_nxt, drop_nxt, lvl_nxt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [29:0]      addr_nxt;
    logic             acc, abort, rsp_live;

    always_comb begin
        acc      = fl_req && fl_gnt;
        abort    = wr_cnt && (wdata[CNT_W-1:0] == '0);
        rsp_live = fl_rvalid && (drop_q == '0);
        push     = rsp_live && !abort;
        lvl_nxt  = SUM_W'(fifo_lvl) + SUM_W'(push) - SUM_W'(pop);
        if (abort) begin
            live_nxt = '0;
            drop_nxt = SUM_W'(drop_q) + SUM_W'(live_q) + SUM_W'(acc) - SUM_W'(fl_rvalid);
        end else begin
            live_nxt = SUM_W'(live_q) + SUM_W'(acc) - SUM_W'(rsp_live);
            drop_nxt = SUM_W'(drop_q) - SUM_W'(fl_rvalid && (drop_q != '0));
        end
        if (wr_cnt)   cnt_nxt = wdata[CNT_W-1:0];
        else if (acc) cnt_nxt = cnt_q - 1'b1;
        else          cnt_nxt = cnt_q;
        if (wr_addr)  addr_nxt = wdata[31:2];
        else if (acc) addr_nxt = addr_q + 1'b1;
        else          addr_nxt = addr_q;
        if (cnt_nxt == '0)
            state_nxt = ST_IDLE;
        else if ((lvl_nxt + live_nxt >= SUM_W'(DEPTH)) ||
                 (drop_nxt + live_nxt >= SUM_W'(OUT_MAX)))
            state_nxt = ST_HOLD;
        else
            state_nxt = ST_STREAM;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            live_q  <= '0;
            drop_q  <= '0;
            cnt_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_nxt;
            live_q  <= OUT_W'(live_nxt);
            drop_q  <= OUT_W'(drop_nxt);
            cnt_q   <= cnt_nxt;
            addr_q  <= addr_nxt;
        end
    end

    always_comb begin
        fl_req  = 1'b0;
        fl_addr = {addr_q, 2'b00};
        unique case (state_q)
            ST_IDLE:   fl_req = 1'b0;
            ST_STREAM: fl_req = !xip_busy;
            ST_HOLD:   fl_req = 1'b0;
            default:   fl_req = 1'b0;
        endcase
    end

    p_xip_priority_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xip_busy |-> !fl_req);

    p_stop_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> !fl_req);

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !wr_addr) |=> (addr_q == $past(addr_q) + 30'd1));

    p_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> (SUM_W'(fifo_lvl) + SUM_W'(live_q) < SUM_W'(DEPTH)));

    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !wr_addr) |=> !fl_req);
endmodule

// File: rtl/flash_stream_engine.sv
module flash_stream_engine
    import fse_pkg::*;
#(
    parameter int CNT_W   = 22,
    parameter int DEPTH   = 2,
    parameter int OUT_MAX = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        xip_busy,
    output logic        fl_req,
    output logic [31:0] fl_addr,
    input  logic        fl_gnt,
    input  logic        fl_rvalid,
    input  logic [31:0] fl_rdata
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [LVL_W-1:0] lvl;
    logic [31:0]      head;
    logic [29:0]      addr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             empty, full, push, pop;

    assign pop = reg_rd && (reg_sel == SEL_DATA) && !empty;

    fse_ctrl #(.CNT_W(CNT_W), .DEPTH(DEPTH), .OUT_MAX(OUT_MAX), .LVL_W(LVL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_addr   (reg_wr && (reg_sel == SEL_ADDR)),
        .wr_cnt    (reg_wr && (reg_sel == SEL_CNT)),
        .wdata     (reg_wdata),
        .xip_busy  (xip_busy),
        .fl_gnt    (fl_gnt),
        .fl_rvalid (fl_rvalid),
        .fifo_lvl  (lvl),
        .pop       (pop),
        .fl_req    (fl_req),
        .fl_addr   (fl_addr),
        .addr_q    (addr_q),
        .cnt_q     (cnt_q),
        .push      (push)
    );

    fse_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (fl_rdata),
        .pop       (pop),
        .head      (head),
        .level     (lvl),
        .empty     (empty),
        .full      (full)
    );

    always_comb begin
        unique case (reg_sel)
            SEL_ADDR: reg_rdata = {addr_q, 2'b00};
            SEL_CNT:  reg_rdata = 32'(cnt_q);
            SEL_DATA: reg_rdata = head;
            SEL_STAT: reg_rdata = {30'd0, full, empty};
            default:  reg_rdata = 32'd0;
        endcase
    end

    p_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: tb/test_flash_stream_engine.sv
module test_flash_stream_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        xip_busy = 1'b0;
    logic        fl_req;
    logic [31:0] fl_addr;
    logic        fl_gnt = 1'b1;
    logic        fl_rvalid = 1'b0;
    logic [31:0] fl_rdata = 32'd0;

    int checks = 0, fails = 0, cyc = 0, lat = 2;
    logic [31:0] qa [16];
    int          qt [16];
    int          qh = 0, qn = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    flash_stream_engine i_flash_stream_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xip_busy(xip_busy), .fl_req(fl_req), .fl_addr(fl_addr),
        .fl_gnt(fl_gnt), .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    // flash model: in-order responses after lat cycles
    always @(negedge clk) begin
        cyc++;
        if (qn > 0 && (cyc - qt[qh]) >= lat) begin
            fl_rvalid = 1'b1;
            fl_rdata  = pat(qa[qh]);
            qh = (qh + 1) % 16;
            qn--;
        end else begin
            fl_rvalid = 1'b0;
        end
        #1;
        if (rst_n && fl_req && fl_gnt) begin
            qa[(qh + qn) % 16] = fl_addr;
            qt[(qh + qn) % 16] = cyc;
            qn++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        reg_rd = 1'b1; reg_sel = sel;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic expect_reg(input logic [1:0] sel, input logic [31:0] exp, input string req);
        logic [31:0] d;
        rd(sel, d);
        check(d === exp, req, d, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {sel, write data, expected readback}; xip_busy held so counts never run
    localparam logic [65:0] VEC [0:5] = '{
        {2'd0, 32'h1234_5677, 32'h1234_5674},   // R2
        {2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFC},   // R2
        {2'd0, 32'h0000_0003, 32'h0000_0000},   // R2
        {2'd1, 32'hFFFF_FFFF, 32'h003F_FFFF},   // R3
        {2'd1, 32'h0040_0005, 32'h0000_0005},   // R3
        {2'd1, 32'h0000_0000, 32'h0000_0000}    // R3
    };

    initial begin
        logic [31:0] d;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(fl_req === 1'b0, "R1 fl_req", {31'd0, fl_req}, 32'd0);
        @(negedge clk);
        expect_reg(2'd0, 32'd0, "R1 addr");
        expect_reg(2'd1, 32'd0, "R1 count");
        expect_reg(2'd3, 32'd1, "R1 status");

        xip_busy = 1'b1;
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][65:64], VEC[i][63:32]);
            expect_reg(VEC[i][65:64], VEC[i][31:0], "R2/R3 table");
        end
        xip_busy = 1'b0;
        idle(2);

        // R3/R4/R7: three words from 0x100
        wr(2'd0, 32'h100);
        wr(2'd1, 32'd3);
        #1;
        check(fl_req === 1'b1, "R3 req", {31'd0, fl_req}, 32'd1);
        check(fl_addr === 32'h100, "R3 addr", fl_addr, 32'h100);
        @(negedge clk);
        idle(20);
        #1 check(fl_req === 1'b0, "R7 held", {31'd0, fl_req}, 32'd0);
        @(negedge clk);
        expect_reg(2'd1, 32'd1, "R7 count");
        expect_reg(2'd0, 32'h108, "R4 addr");
        expect_reg(2'd3, 32'd2, "R6 full");
        expect_reg(2'd2, pat(32'h100), "R8 pop1");
        idle(10);
        expect_reg(2'd1, 32'd0, "R4 count");
        expect_reg(2'd0, 32'h10C, "R4 addr end");
        expect_reg(2'd2, pat(32'h104), "R6 order2");
        expect_reg(2'd2, pat(32'h108), "R6 order3");
        expect_reg(2'd2, 32'd0, "R9 empty read");
        expect_reg(2'd3, 32'd1, "R9 status");

        // R5: execute-in-place traffic has priority
        xip_busy = 1'b1;
        wr(2'd0, 32'h400);
        wr(2'd1, 32'd2);
        begin
            bit seen = 0;
            for (int i = 0; i < 6; i++) begin
                #1 if (fl_req !== 1'b0) seen = 1;
                @(negedge clk);
            end
            check(!seen, "R5 no req", {31'd0, seen}, 32'd0);
        end
        expect_reg(2'd1, 32'd2, "R5 count");
        xip_busy = 1'b0;
        idle(15);
        expect_reg(2'd1, 32'd0, "R5 resumed");
        expect_reg(2'd2, pat(32'h400), "R5 data1");
        expect_reg(2'd2, pat(32'h404), "R5 data2");

        // R10: abort with reads in flight, then restart
        lat = 6;
        wr(2'd0, 32'h200);
        wr(2'd1, 32'd4);
        idle(2);
        wr(2'd1, 32'd0);
        #1 check(fl_req === 1'b0, "R10 stop", {31'd0, fl_req}, 32'd0);
        @(negedge clk);
        wr(2'd0, 32'h300);
        wr(2'd1, 32'd1);
        idle(30);
        expect_reg(2'd1, 32'd0, "R10 count");
        expect_reg(2'd2, pat(32'h300), "R10 new data");
        expect_reg(2'd3, 32'd1, "R10 dropped stale");
        expect_reg(2'd2, 32'd0, "R10 nothing else");
        lat = 2;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule